// File: doc/BRIEF.md
# Population Count Table Generator

This block builds, on a single start pulse, a table that holds the number of set bits of every index from 0 up to a requested limit. It writes entry 0 as zero first. It then walks the indices upward in order. For each index it finds the highest power of two not above the index, using a 32-bit leading-zero count. It reads the table entry at the index minus that power and writes the value plus one at the index. No index is ever counted bit by bit.

The table sits in a local single-port memory. Each index takes one read cycle and one write cycle. The limit is clamped to the last address the memory holds. When the table is finished the block pulses done and reports how many entries it produced. While the block is idle, a read port returns any entry one cycle after the address is presented.

Top module: `popcnt_table`

## Requirements
- R1: During and after reset, busy and done are 0 and entries is 0.
- R2: Entry 0 reads as 0 after every run. A limit of 0 produces exactly one entry.
- R3: After a run with effective limit m, every entry i with 1 <= i <= m reads as the number of 1 bits in i. For example, a limit of 8 gives 0,1,1,2,1,2,2,3,1.
- R4: While done is high, entries equals m+1.
- R5: busy is high from the cycle after start is sampled up to the cycle before done. done is high for exactly one cycle, and busy is low in that cycle.
- R6: A start pulse that arrives while busy is high is ignored. The run in progress keeps its own limit and timing.
- R7: A limit above DEPTH-1, where DEPTH = 2**IDX_W, is treated as DEPTH-1. entries is then DEPTH and every entry is correct.
- R8: done rises exactly 2m+1 rising clock edges after the edge that samples start.
- R9: While idle, rd_data shows the entry at rd_addr one clock edge after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (sampled while idle) |
| limit | input | N_W | Requested highest index n |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| entries | output | IDX_W+1 | Number of entries produced |
| rd_addr | input | IDX_W | Table read address (idle only) |
| rd_data | output | CNT_W | Table entry, one cycle after rd_addr |

## Verification
The bench targets several corner cases. A limit of zero must finish in one step with a single zero entry; a design that skipped the seed write would leave entry 0 stale, and one that entered the loop anyway would produce two entries. Exact powers of two and all-ones indices such as 8 and 63 test the leading-zero search; an off-by-one shift would read the wrong earlier entry and give a count that is wrong by one or more. An oversized limit must clamp to a full table, or the entry count and the timing would be wrong. A start pulse in mid-run must not shorten, restart or relimit the run, which the bench detects through the done timing and the reported count.

// File: rtl/popc_pkg.sv
package popc_pkg;
    // Width of the leading-zero search (fixed at 32 bits by the algorithm).
    localparam int CLZ_W  = 32;
    localparam int CLZ_LG = $clog2(CLZ_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED,
        ST_FETCH,
        ST_STORE,
        ST_FIN
    } seq_state_t;

    // Shift amount that turns a leading-zero count into the top-bit position.
    function automatic logic [CLZ_LG-1:0] top_bit_pos(input logic [CLZ_LG:0] lz);
        logic [CLZ_LG:0] pos;
        pos = (CLZ_LG+1)'(CLZ_W - 1) - lz;
        return pos[CLZ_LG-1:0];
    endfunction
endpackage

// File: rtl/popc_clz.sv
module popc_clz #(
    parameter int W  = 32,
    localparam int LG = $clog2(W)
) (
    input  logic [W-1:0] din,
    output logic [LG:0]  lz
);
    logic [W-1:0] val [0:LG];
    logic [LG:0]  cnt [0:LG];

    assign val[0] = din;
    assign cnt[0] = '0;

    // Halving search: each stage tests the top S bits and shifts them out when clear.
    for (genvar k = 0; k < LG; k++) begin : g_stage
        localparam int S = W >> (k + 1);
        logic clear;
        assign clear      = (val[k][W-1 -: S] == '0);
        assign val[k+1]   = clear ? (val[k] << S) : val[k];
        assign cnt[k+1]   = clear ? (cnt[k] + (LG+1)'(S)) : cnt[k];
    end

    assign lz = (din == '0) ? (LG+1)'(W) : cnt[LG];

    // R3: the bit the count points at is the leading one
    always_comb begin
        if (din != '0 && lz < (LG+1)'(W)) begin
            p_leading_one_r3: assert (din[(LG+1)'(W-1) - lz] == 1'b1);
        end
    end
endmodule

// File: rtl/popc_ram.sv
module popc_ram #(
    parameter int AW = 6,
    parameter int DW = 3,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
        rdata <= store[addr];
    end
endmodule

// File: rtl/popc_seq.sv
module popc_seq
    import popc_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int N_W   = 17,
    parameter int CNT_W = 3,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N_W-1:0]   limit,
    input  logic [IDX_W-1:0] ext_addr,
    input  logic [CLZ_LG:0]  lz,
    input  logic [CNT_W-1:0] mem_rd,
    output logic [CLZ_W-1:0] clz_in,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_addr,
    output logic [CNT_W-1:0] mem_wd,
    output logic             busy,
    output logic             done,
    output logic [IDX_W:0]   entries
);
    seq_state_t       state_q;
    logic [IDX_W-1:0] idx_q, last_q, lim_eff, hp2, src;

    assign lim_eff = (limit > N_W'(DEPTH - 1)) ? IDX_W'(DEPTH - 1) : limit[IDX_W-1:0];
    assign clz_in  = CLZ_W'(idx_q);
    assign hp2     = IDX_W'(1) << top_bit_pos(lz);
    assign src     = idx_q - hp2;

    assign busy = (state_q == ST_SEED) || (state_q == ST_FETCH) || (state_q == ST_STORE);
    assign done = (state_q == ST_FIN);

    always_comb begin
        mem_we   = 1'b0;
        mem_wd   = '0;
        mem_addr = ext_addr;
        unique case (state_q)
            ST_SEED:  begin mem_we = 1'b1; mem_addr = '0; end
            ST_FETCH: mem_addr = src;
            ST_STORE: begin mem_we = 1'b1; mem_addr = idx_q; mem_wd = mem_rd + CNT_W'(1); end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
            entries <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    last_q  <= lim_eff;
                    idx_q   <= '0;
                    state_q <= ST_SEED;
                end
                ST_SEED: begin
                    if (last_q == '0) begin
                        entries <= (IDX_W+1)'(1);
                        state_q <= ST_FIN;
                    end else begin
                        idx_q   <= IDX_W'(1);
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_STORE;
                ST_STORE: begin
                    if (idx_q == last_q) begin
                        entries <= (IDX_W+1)'(last_q) + (IDX_W+1)'(1);
                        state_q <= ST_FIN;
                    end else begin
                        idx_q   <= idx_q + IDX_W'(1);
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && entries == '0));
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(last_q));
    p_idx_bound_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx_q <= last_q));
    p_fetch_store_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (state_q == ST_STORE));
    p_entries_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (entries == (IDX_W+1)'(last_q) + (IDX_W+1)'(1)));
endmodule

// File: rtl/popcnt_table.sv
module popcnt_table
    import popc_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int N_W   = 17,
    localparam int CNT_W = $clog2(IDX_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N_W-1:0]   limit,
    output logic             busy,
    output logic             done,
    output logic [IDX_W:0]   entries,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_data
);
    logic [CLZ_W-1:0] clz_in;
    logic [CLZ_LG:0]  lz;
    logic             mem_we;
    logic [IDX_W-1:0] mem_addr;
    logic [CNT_W-1:0] mem_wd, mem_rd;

    popc_clz #(.W(CLZ_W)) u_clz (
        .din (clz_in),
        .lz  (lz)
    );

    popc_ram #(.AW(IDX_W), .DW(CNT_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wd),
        .rdata (mem_rd)
    );

    popc_seq #(.IDX_W(IDX_W), .N_W(N_W), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .limit    (limit),
        .ext_addr (rd_addr),
        .lz       (lz),
        .mem_rd   (mem_rd),
        .clz_in   (clz_in),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wd   (mem_wd),
        .busy     (busy),
        .done     (done),
        .entries  (entries)
    );

    assign rd_data = mem_rd;
endmodule

// File: tb/popcnt_table_tb.sv
module popcnt_table_tb;
    localparam int IDX_W = 6;
    localparam int N_W   = 17;
    localparam int DEPTH = 1 << IDX_W;
    localparam int CNT_W = $clog2(IDX_W + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [N_W-1:0]   limit = '0;
    logic             busy, done;
    logic [IDX_W:0]   entries;
    logic [IDX_W-1:0] rd_addr = '0;
    logic [CNT_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int    addr;
        int    val;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_req = 1'b0, rd_req_d = 1'b0;

    always #5 clk = ~clk;

    popcnt_table #(.IDX_W(IDX_W), .N_W(N_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .limit(limit),
        .busy(busy), .done(done), .entries(entries),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: compares each returned table entry with the scoreboard.
    always_ff @(posedge clk) rd_req_d <= rd_req;
    always @(negedge clk) begin
        if (rd_req_d && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(int'(rd_data) == e.val, e.tag, int'(rd_data), e.val);
        end
    end

    // Driver: one run, with an optional foreign start pulse mid-run.
    task automatic run(input int n, input int inject_n);
        int m, cyc;
        bit busy_ok;
        m = (n > DEPTH - 1) ? DEPTH - 1 : n;
        @(negedge clk);
        start = 1'b1;
        limit = N_W'(n);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        busy_ok = 1;
        while (!done && cyc < 400) begin
            if (!busy) busy_ok = 0;
            if (inject_n >= 0 && cyc == 3) begin
                start = 1'b1;
                limit = N_W'(inject_n);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(busy_ok, "R5 busy held during run", busy_ok, 1);
        check(!busy, "R5 busy low with done", busy, 0);
        check(cyc == 2 * m + 2, "R8/R6 done timing", cyc, 2 * m + 2);
        check(int'(entries) == m + 1, (n > DEPTH - 1) ? "R7 clamped entries" : "R4 entries",
              int'(entries), m + 1);
        @(negedge clk);
        check(!done, "R5 done single cycle", done, 0);
        // Read the table back through the idle read port.
        for (int a = 0; a <= m; a++) begin
            exp_t e;
            e.addr = a;
            e.val  = $countones(a);
            e.tag  = (a == 0) ? "R2 entry zero" : ((n > DEPTH - 1) ? "R7 clamped entry" : "R3/R9 entry");
            exp_q.push_back(e);
            rd_addr = IDX_W'(a);
            rd_req  = 1'b1;
            @(negedge clk);
        end
        rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && entries == '0, "R1 reset state", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && entries == '0, "R1 idle after reset", int'(entries), 0);
        run(5, -1);
        run(8, -1);
        run(0, -1);
        run(20, -1);
        run(8, 3);      // R6: the mid-run start with limit 3 must not matter
        run(63, -1);
        run(100000, -1); // R7
        check(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule